// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt events from up to sixteen peripheral sources into a pending-status register and gates them with a mask register to drive one interrupt request line toward the CPU. Each source raises its event as a single-cycle pulse on its own input bit. The pending bit stays set until software clears it.

Software reaches both registers through a simple register bus that carries 16-bit and 32-bit accesses. To acknowledge, software writes a value in which a 0 clears the matching pending bit and a 1 leaves it as it is. The new pending bits are the old ones ANDed with the written data. After any status or mask write, the request line reflects the updated registers. Source input 3 is the DMA controller's interrupt.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous active-high reset, pending and mask are 0, `cpu_irq` is low and `bus_rdata` is 0.
- R2: A read at byte offset 0x1070 returns the pending register and a read at 0x1074 returns the mask. The value is zero-extended to 32 bits and appears on `bus_rdata` one cycle after the access. `bus_rdata` holds its value when no read is made.
- R3: A 1 on `src_pulse[i]` sets pending bit i at the next clock edge.
- R4: A write to 0x1070 replaces the pending bits with their AND against `bus_wdata[15:0]`. Written 0s clear bits and written 1s leave them unchanged.
- R5: When a source pulse and an acknowledging write that clears the same bit fall in the same cycle, the bit remains set.
- R6: A write to 0x1074 loads `bus_wdata[15:0]` into the mask.
- R7: `cpu_irq` is high exactly when (pending AND mask) is nonzero. It follows a status write, a mask write or a source pulse at the same clock edge that updates the registers.
- R8: On a 32-bit write, `bus_wdata[31:16]` is ignored. A 32-bit access selects the register whatever the value of address bit 1.
- R9: A 16-bit access (`bus_wide`=0) with address bit 1 set reaches the upper, unused half of a register. It reads 0 and its write changes nothing.
- R10: An access to any other offset, or one with address bit 0 set, reads 0 and its write changes no register.
- R11: Pending bit 3 is the DMA source. A pulse on `src_pulse[3]` sets only bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 16 | Byte offset inside the I/O region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_pulse | input | 16 | Per-source single-cycle event pulses |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
Corrupted pending or mask state shows at the ports in two ways. It shows on `cpu_irq` at the next clock edge whenever the masked set changes. It also shows on `bus_rdata` one cycle after the next read of the corrupted register. The bench therefore compares `cpu_irq` with a reference model after every cycle and reads both registers often, so a lost, stuck or wrongly cleared bit is seen within a few cycles. Directed cases cover the corners where a decode or priority slip stays hidden otherwise: same-cycle pulse and acknowledge, upper-half accesses, high write data, and stray addresses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_STAT = 2'd1,
    TGT_MASK = 2'd2
  } reg_tgt_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] STATUS_OFS = 16'h1070,
  parameter logic [15:0] MASK_OFS   = 16'h1074
) (
  input  logic              sel,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  output reg_tgt_e          tgt
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

  logic lane_ok;

  // a narrow access to the upper halfword reaches no storage
  assign lane_ok = !addr[0] && (wide || !addr[1]);

  always_comb begin
    tgt = TGT_NONE;
    if (sel && lane_ok) begin
      if (addr[ADDR_W-1:2] == STAT_A[ADDR_W-1:2])      tgt = TGT_STAT;
      else if (addr[ADDR_W-1:2] == MASK_A[ADDR_W-1:2]) tgt = TGT_MASK;
    end
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack_en,
  input  logic [NSRC-1:0] ack_data,
  input  logic [NSRC-1:0] src,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] pend_d
);
  logic [NSRC-1:0] kept;

  // per bit: keep on a written 1, new events override the clear
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    assign kept[i]   = ack_en ? (pend_q[i] & ack_data[i]) : pend_q[i];
    assign pend_d[i] = kept[i] | src[i];
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(ack_en) |-> ((pend_q & $past(pend_q)) == $past(pend_q))); // R4
  AST_SRC_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((pend_q & $past(src)) == $past(src))); // R5
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_data,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] mask_d
);
  assign mask_d = wr_en ? wr_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(wr_en) |-> $stable(mask_q)); // R6
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqc_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          BUS_W      = 32,
  parameter int          NSRC       = 16,
  parameter logic [15:0] STATUS_OFS = 16'h1070,
  parameter logic [15:0] MASK_OFS   = 16'h1074
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NSRC-1:0]   src_pulse,
  output logic              cpu_irq
);
  localparam int PAD_W = BUS_W - NSRC;

  reg_tgt_e        tgt;
  logic [NSRC-1:0] pend_q, pend_d, mask_q, mask_d;
  logic [NSRC-1:0] wr_val;
  logic            rd_en;

  assign wr_val = bus_wdata[NSRC-1:0];
  assign rd_en  = bus_sel && !bus_wr;

  irqc_decode #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .sel(bus_sel), .wide(bus_wide), .addr(bus_addr), .tgt(tgt)
  );

  irqc_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst),
    .ack_en(bus_wr && tgt == TGT_STAT), .ack_data(wr_val),
    .src(src_pulse), .pend_q(pend_q), .pend_d(pend_d)
  );

  irqc_mask #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && tgt == TGT_MASK), .wr_data(wr_val),
    .mask_q(mask_q), .mask_d(mask_d)
  );

  // request computed from next-state so it moves with the registers
  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= |(pend_d & mask_d);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_en) begin
      unique case (tgt)
        TGT_STAT: bus_rdata <= {{PAD_W{1'b0}}, pend_q};
        TGT_MASK: bus_rdata <= {{PAD_W{1'b0}}, mask_q};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (!cpu_irq && pend_q == '0 && mask_q == '0)); // R1
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == |(pend_q & mask_q)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(rd_en) |-> $stable(bus_rdata)); // R2
  AST_RDATA_PAD: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:NSRC] == '0); // R2
endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb_top;
  logic        clk = 0;
  logic        rst;
  logic        bus_sel, bus_wr, bus_wide;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] src_pulse;
  logic        cpu_irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_pend, m_mask;
  logic [31:0] m_rd;

  always #5 clk = ~clk;

  irq_status_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_pulse(src_pulse), .cpu_irq(cpu_irq)
  );

  // 0 none, 1 status, 2 mask
  function automatic int tgt_of(logic [15:0] a, logic w);
    if (a[0] || (!w && a[1])) return 0;
    if (a[15:2] == 14'(16'h1070 >> 2)) return 1;
    if (a[15:2] == 14'(16'h1074 >> 2)) return 2;
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle plus sources; model updated, outputs checked at negedge
  task automatic step(string req, logic sel, logic wr, logic wide,
                      logic [15:0] a, logic [31:0] d, logic [15:0] s);
    int t;
    bus_sel = sel; bus_wr = wr; bus_wide = wide; bus_addr = a; bus_wdata = d; src_pulse = s;
    t = sel ? tgt_of(a, wide) : 0;
    if (sel && !wr) m_rd = (t == 1) ? {16'h0, m_pend} : (t == 2) ? {16'h0, m_mask} : 32'h0;
    if (sel && wr && t == 1) m_pend = m_pend & d[15:0];
    m_pend = m_pend | s;
    if (sel && wr && t == 2) m_mask = d[15:0];
    @(posedge clk);
    @(negedge clk);
    chk({req, " R7 irq"}, {31'h0, cpu_irq}, {31'h0, |(m_pend & m_mask)});
    chk({req, " R2 rdata"}, bus_rdata, m_rd);
    bus_sel = 0; src_pulse = '0;
  endtask

  task automatic rd(string req, logic [15:0] a, logic w);
    step(req, 1, 0, w, a, 32'h0, 16'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; bus_sel = 0; bus_wr = 0; bus_wide = 0; bus_addr = 0; bus_wdata = 0; src_pulse = 0;
    m_pend = 0; m_mask = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 irq", {31'h0, cpu_irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd("R1 pend", 16'h1070, 1);
    rd("R1 mask", 16'h1074, 0);

    step("R3 src", 0, 0, 0, 0, 0, 16'h00A5);
    rd("R3 read", 16'h1070, 0);
    step("R6 mask", 1, 1, 0, 16'h1074, 32'h0000_0004, 16'h0);
    chk("R7 irq high", {31'h0, cpu_irq}, 32'h1);
    step("R4 ack", 1, 1, 0, 16'h1070, 32'hFFFF_FFFB, 16'h0);
    chk("R4 irq drop", {31'h0, cpu_irq}, 32'h0);
    rd("R4 read", 16'h1070, 1);
    chk("R4 value", bus_rdata, 32'h0000_00A1);
    step("R5 race", 1, 1, 0, 16'h1070, 32'h0000_0000, 16'h0001);
    rd("R5 read", 16'h1070, 0);
    chk("R5 value", bus_rdata, 32'h0000_0001);
    step("R11 dma", 0, 0, 0, 0, 0, 16'h0008);
    step("R11 mask", 1, 1, 1, 16'h1074, 32'h0000_0008, 16'h0);
    chk("R11 irq", {31'h0, cpu_irq}, 32'h1);
    rd("R11 read", 16'h1070, 1);
    chk("R11 value", bus_rdata, 32'h0000_0009);
    step("R8 hi", 1, 1, 1, 16'h1076, 32'hABCD_1234, 16'h0);
    rd("R8 read", 16'h1074, 1);
    chk("R8 value", bus_rdata, 32'h0000_1234);
    step("R9 upper wr", 1, 1, 0, 16'h1076, 32'h0, 16'h0);
    rd("R9 upper rd", 16'h1072, 0);
    chk("R9 zero", bus_rdata, 32'h0);
    rd("R9 mask kept", 16'h1074, 0);
    chk("R9 value", bus_rdata, 32'h0000_1234);
    step("R10 stray wr", 1, 1, 1, 16'h1080, 32'h0, 16'h0);
    step("R10 odd wr", 1, 1, 0, 16'h1071, 32'h0, 16'h0);
    rd("R10 pend kept", 16'h1070, 0);
    chk("R10 value", bus_rdata, 32'h0000_0009);

    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      case ($urandom_range(0, 5))
        0: a = 16'h1070; 1: a = 16'h1074; 2: a = 16'h1072;
        3: a = 16'h1076; 4: a = 16'h1071; default: a = 16'h1080;
      endcase
      step("R3 R4 R6 rand", $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, a, $urandom(),
           ($urandom_range(0, 3) == 0) ? 16'($urandom()) : 16'h0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule